// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Controller

This block sits between a synchronous host and an asynchronous static RAM of 256K bytes. The host presents one word at a time through a valid/ready request carrying an 18-bit address, a write flag and write data. The controller then runs a read or write cycle on the memory pins whose phase lengths meet the memory's nanosecond minimums. Read data comes back on a single-clock response pulse.

Every phase length is an elaboration-time count. It is derived from the clock period and a speed-grade parameter by rounding the required nanoseconds up to whole clocks, with a floor of one clock. All memory pins come straight from flops that are loaded from the next state, so the pins change only at clock edges and never glitch. The bidirectional data bus is split into an output byte, a drive enable and an input byte. The controller drives the bus only while a write pulse is active. It leaves a float gap after a read before it drives again.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is held and after it is released with no request, `mem_sel_n` is 1, `mem_sel` is 0, `mem_we_n` is 1, `mem_oe_n` is 1, `mem_dq_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: `mem_we_n` or `mem_oe_n` is low only while `mem_sel_n` is 0 and `mem_sel` is 1 at the same time. Whenever `req_ready` is 1, both selects are inactive and all strobes are high.
- R3: A read holds both selects active with `mem_oe_n` low and `mem_we_n` high for RD clocks, and `mem_addr` is stable throughout. RD is the rounded-up clock count of the largest of cycle time, address access time and output-enable access time.
- R4: Read data is sampled from `mem_dq_in` on the last clock of the read phase. It is presented on `rsp_rdata` with `rsp_valid` high for exactly one clock, in the same clock that `req_ready` returns. `rsp_valid` never pulses for a write.
- R5: A write holds `mem_we_n` low for WP clocks with `mem_oe_n` high throughout. `mem_dq_oe` is high and `mem_addr` and `mem_dq_out` are stable throughout. `mem_dq_oe` is never high outside a write pulse. WP is the rounded-up count of the largest of write pulse width, select-to-end-of-write, address-valid-to-end-of-write and data setup.
- R6: After the write pulse ends, the controller waits REC clocks with the memory deselected. REC is the write cycle count minus WP, but never less than 1.
- R7: A write that follows a read spends TA clocks in a turnaround gap before its pulse starts. TA is the rounded-up output float time. `mem_dq_oe` never rises while the memory can still be driving the bus.
- R8: Address, write data and write flag are taken from the request in the clock it is accepted. Later changes on those inputs have no effect on that cycle. `req_ready` stays low until the whole cycle, including the gaps, has elapsed.
- R9: `SPEED_GRADE` 0 selects the 55 ns grade and 1 selects the 70 ns grade. Every phase count is ceil(ns / `CLK_PERIOD_NS`) with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | ADDR_W | Word address of the request |
| req_wr | input | 1 | 1 for write, 0 for read |
| req_wdata | input | DATA_W | Byte to write |
| rsp_valid | output | 1 | One-clock pulse with read data |
| rsp_rdata | output | DATA_W | Read data |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_sel_n | output | 1 | Active-low memory select |
| mem_sel | output | 1 | Active-high memory select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | DATA_W | Byte driven onto the data bus |
| mem_dq_oe | output | 1 | Tri-state enable for `mem_dq_out` |
| mem_dq_in | input | DATA_W | Byte read from the data bus |

## Verification
The hardest case to reach from the ports is a write that starts right after a read. In that case the memory may still be driving the bus while the controller wants to drive it. The bench runs a data sweep in which each read is followed immediately by the next write. Its memory model keeps driving for the float time after the output enable is removed and flags any overlap with `mem_dq_oe`. The model also returns corrupted data until the access time has elapsed, so a capture one clock too early shows up as wrong read data rather than passing silently.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_TURN    = 3'd1,
    ST_READ    = 3'd2,
    ST_WRITE   = 3'd3,
    ST_RECOVER = 3'd4
  } ctl_state_e;

  // Nanosecond minimums of one speed grade
  typedef struct packed {
    int unsigned rd_cycle;
    int unsigned rd_access;
    int unsigned oe_access;
    int unsigned wr_cycle;
    int unsigned we_pulse;
    int unsigned sel_to_end;
    int unsigned data_setup;
    int unsigned float_ns;
  } grade_ns_t;

  // Clock counts of each phase
  typedef struct packed {
    int unsigned rd;
    int unsigned wp;
    int unsigned rec;
    int unsigned ta;
  } phase_clk_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned ns_to_clk(input int unsigned ns, input int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic grade_ns_t grade_ns(input int unsigned grade);
    grade_ns_t t;
    if (grade == 0) begin
      t.rd_cycle   = 55;
      t.rd_access  = 55;
      t.oe_access  = 25;
      t.wr_cycle   = 55;
      t.we_pulse   = 40;
      t.sel_to_end = 45;
      t.data_setup = 25;
      t.float_ns   = 20;
    end else begin
      t.rd_cycle   = 70;
      t.rd_access  = 70;
      t.oe_access  = 35;
      t.wr_cycle   = 70;
      t.we_pulse   = 50;
      t.sel_to_end = 60;
      t.data_setup = 30;
      t.float_ns   = 25;
    end
    return t;
  endfunction

  function automatic phase_clk_t phase_clocks(input int unsigned grade, input int unsigned period);
    grade_ns_t   t;
    phase_clk_t  p;
    int unsigned wc;
    t    = grade_ns(grade);
    p.rd = ns_to_clk(max2(max2(t.rd_cycle, t.rd_access), t.oe_access), period);
    p.wp = ns_to_clk(max2(max2(t.we_pulse, t.sel_to_end), t.data_setup), period);
    wc   = ns_to_clk(t.wr_cycle, period);
    p.rec = (wc > p.wp) ? (wc - p.wp) : 1;
    p.ta = ns_to_clk(t.float_ns, period);
    return p;
  endfunction

endpackage

// File: rtl/sram_rst_sync.sv
module sram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = load | (cnt_q != '0);

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int unsigned CNT_W   = 2,
  parameter int unsigned RD_CLK  = 3,
  parameter int unsigned WP_CLK  = 3,
  parameter int unsigned REC_CLK = 1,
  parameter int unsigned TA_CLK  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_wr,
  input  logic             expired,
  output ctl_state_e       state_d,
  output logic             req_ready,
  output logic             timer_load,
  output logic [CNT_W-1:0] timer_val,
  output logic             capture
);
  ctl_state_e st_q;
  ctl_state_e st_d;
  logic       hot_q;
  logic       hot_d;

  // next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (req_valid) st_d = req_wr ? (hot_q ? ST_TURN : ST_WRITE) : ST_READ;
      ST_TURN:    if (expired)   st_d = ST_WRITE;
      ST_READ:    if (expired)   st_d = ST_IDLE;
      ST_WRITE:   if (expired)   st_d = ST_RECOVER;
      ST_RECOVER: if (expired)   st_d = ST_IDLE;
      default:                   st_d = ST_IDLE;
    endcase
  end

  // bus may still be driven by the memory after a read
  always_comb begin
    hot_d = hot_q;
    if (st_q == ST_READ && expired)      hot_d = 1'b1;
    else if (st_q == ST_TURN && expired) hot_d = 1'b0;
  end

  always_comb begin
    unique case (st_d)
      ST_TURN:    timer_val = CNT_W'(TA_CLK - 1);
      ST_READ:    timer_val = CNT_W'(RD_CLK - 1);
      ST_WRITE:   timer_val = CNT_W'(WP_CLK - 1);
      ST_RECOVER: timer_val = CNT_W'(REC_CLK - 1);
      default:    timer_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      hot_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      hot_q <= hot_d;
    end
  end

  assign state_d    = st_d;
  assign timer_load = (st_d != st_q);
  assign req_ready  = (st_q == ST_IDLE);
  assign capture    = (st_q == ST_READ) && expired;
endmodule

// File: rtl/sram_pin_io.sv
module sram_pin_io
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  ctl_state_e        state_d,
  input  logic              capture,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic sel_d;
  logic wr_d;
  logic rd_d;

  assign rd_d  = (state_d == ST_READ);
  assign wr_d  = (state_d == ST_WRITE);
  assign sel_d = rd_d | wr_d;

  // strobes registered from next state: glitch-free pins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_sel_n <= 1'b1;
      mem_sel   <= 1'b0;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      mem_sel_n <= ~sel_d;
      mem_sel   <= sel_d;
      mem_we_n  <= ~wr_d;
      mem_oe_n  <= ~rd_d;
      mem_dq_oe <= wr_d;
    end
  end

  // request fields held for the whole cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (fire) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= capture;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rsp_rdata <= '0;
    else if (capture) rsp_rdata <= mem_dq_in;
  end
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned SPEED_GRADE   = 0,
  parameter int unsigned ADDR_W        = 18,
  parameter int unsigned DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam phase_clk_t  PH      = phase_clocks(SPEED_GRADE, CLK_PERIOD_NS);
  localparam int unsigned LONGEST = max2(max2(PH.rd, PH.wp), max2(PH.rec, PH.ta));
  localparam int unsigned CNT_W   = (LONGEST < 2) ? 1 : $clog2(LONGEST);

  logic             rst_int_n;
  logic             expired;
  logic             timer_load;
  logic [CNT_W-1:0] timer_val;
  logic             capture;
  logic             fire;
  ctl_state_e       state_d;

  sram_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (timer_load),
    .load_val (timer_val),
    .expired  (expired)
  );

  sram_ctl_fsm #(
    .CNT_W   (CNT_W),
    .RD_CLK  (PH.rd),
    .WP_CLK  (PH.wp),
    .REC_CLK (PH.rec),
    .TA_CLK  (PH.ta)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_valid  (req_valid),
    .req_wr     (req_wr),
    .expired    (expired),
    .state_d    (state_d),
    .req_ready  (req_ready),
    .timer_load (timer_load),
    .timer_val  (timer_val),
    .capture    (capture)
  );

  assign fire = req_valid & req_ready;

  sram_pin_io #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_io (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .fire       (fire),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .state_d    (state_d),
    .capture    (capture),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_sel_n  (mem_sel_n),
    .mem_sel    (mem_sel),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );
endmodule

// File: rtl/sram_seq_ctrl_checker.sv
module sram_seq_ctrl_checker
  import sram_ctl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned SPEED_GRADE   = 0,
  parameter int unsigned ADDR_W        = 18,
  parameter int unsigned DATA_W        = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_sel_n,
  input logic              mem_sel,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);
  localparam phase_clk_t PH = phase_clocks(SPEED_GRADE, CLK_PERIOD_NS);

  logic [7:0] we_low_cnt;
  logic [7:0] oe_high_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        we_low_cnt <= '0;
    else if (mem_we_n)                 we_low_cnt <= '0;
    else if (we_low_cnt != 8'hff)      we_low_cnt <= we_low_cnt + 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        oe_high_cnt <= 8'hff;
    else if (!mem_oe_n)                oe_high_cnt <= '0;
    else if (oe_high_cnt != 8'hff)     oe_high_cnt <= oe_high_cnt + 8'd1;
  end

  AST_STROBE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || !mem_oe_n) |-> (!mem_sel_n && mem_sel)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && !mem_dq_oe)); // R2

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_sel_n && !$past(mem_sel_n)) |-> $stable(mem_addr)); // R3

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R4

  AST_WE_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n); // R5

  AST_DRIVE_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_we_n); // R5

  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_dq_out)); // R5

  AST_WE_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_cnt == 8'(PH.wp))); // R5

  AST_FLOAT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_high_cnt >= 8'(PH.ta))); // R7
endmodule

bind sram_seq_ctrl sram_seq_ctrl_checker #(
  .CLK_PERIOD_NS (CLK_PERIOD_NS),
  .SPEED_GRADE   (SPEED_GRADE),
  .ADDR_W        (ADDR_W),
  .DATA_W        (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_addr   (mem_addr),
  .mem_sel_n  (mem_sel_n),
  .mem_sel    (mem_sel),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_seq_ctrl_bench.sv
`timescale 1ns/1ps
module sram_seq_ctrl_bench;
  localparam int T     = 20;
  localparam int GRADE = 0;

  function automatic int cdiv(input int ns);
    int c;
    c = (ns + T - 1) / T;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int NS_RC = (GRADE == 0) ? 55 : 70;
  localparam int NS_AA = (GRADE == 0) ? 55 : 70;
  localparam int NS_OE = (GRADE == 0) ? 25 : 35;
  localparam int NS_WC = (GRADE == 0) ? 55 : 70;
  localparam int NS_WP = (GRADE == 0) ? 40 : 50;
  localparam int NS_AW = (GRADE == 0) ? 45 : 60;
  localparam int NS_DW = (GRADE == 0) ? 25 : 30;
  localparam int NS_HZ = (GRADE == 0) ? 20 : 25;
  localparam int EXP_RD  = cdiv(imax(imax(NS_RC, NS_AA), NS_OE));
  localparam int EXP_WP  = cdiv(imax(imax(NS_WP, NS_AW), NS_DW));
  localparam int EXP_WC  = cdiv(NS_WC);
  localparam int EXP_REC = (EXP_WC > EXP_WP) ? EXP_WC - EXP_WP : 1;
  localparam int EXP_TA  = cdiv(NS_HZ);
  localparam int VALID_NS = imax(NS_AA, NS_OE);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [17:0] req_addr = '0;
  logic        req_wr = 1'b0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [17:0] mem_addr;
  logic        mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = '0;

  int n_checks = 0;
  int n_errors = 0;
  int sel_viol = 0;
  int turn_events = 0;
  bit last_read = 1'b0;

  always #(T/2) clk = ~clk;

  sram_seq_ctrl #(.CLK_PERIOD_NS(T), .SPEED_GRADE(GRADE)) u_sram_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wr(req_wr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory model and pin monitors
  logic [7:0] model_mem [int];
  logic [7:0] shadow [int];

  function automatic logic [7:0] dflt(input logic [17:0] a);
    return a[7:0] ^ a[17:10] ^ 8'h3C;
  endfunction
  function automatic logic [7:0] model_rd(input logic [17:0] a);
    return model_mem.exists(int'(a)) ? model_mem[int'(a)] : dflt(a);
  endfunction

  bit          rd_prev = 0, wr_prev = 0, oe_prev = 0, w_bad = 0;
  int          rd_age = 0, off_age = 1000, w_len = 0;
  logic [17:0] w_addr = '0;
  logic [7:0]  w_data = '0;

  always @(posedge clk) begin
    bit rd_now, wr_now, driving;
    #1;
    rd_now = !mem_sel_n && mem_sel && mem_we_n && !mem_oe_n;
    wr_now = !mem_sel_n && mem_sel && !mem_we_n;
    if ((!mem_we_n || !mem_oe_n) && !(!mem_sel_n && mem_sel)) sel_viol++;
    if (rd_now) begin
      rd_age  = rd_prev ? rd_age + 1 : 0;
      off_age = 0;
    end else if (rd_prev) off_age = 0;
    else if (off_age < 1000) off_age++;
    driving = rd_now || (off_age * T < NS_HZ);
    if (mem_dq_oe && !oe_prev) begin
      if (off_age < 1000) turn_events++;
      check(!driving, "R7 bus drive while memory still drives", off_age, EXP_TA);
    end
    oe_prev = mem_dq_oe;
    if (rd_now) mem_dq_in = ((rd_age + 1) * T >= VALID_NS) ? model_rd(mem_addr) : ~model_rd(mem_addr);
    else        mem_dq_in = 8'h00;
    if (wr_now) begin
      if (!wr_prev) begin
        w_len  = 1;
        w_addr = mem_addr;
        w_data = mem_dq_out;
        w_bad  = !mem_dq_oe || !mem_oe_n;
      end else begin
        w_len++;
        if (mem_addr != w_addr || mem_dq_out != w_data || !mem_dq_oe || !mem_oe_n) w_bad = 1;
      end
    end else if (wr_prev) begin
      model_mem[int'(w_addr)] = w_data;
      check(w_len == EXP_WP, "R5 R9 write pulse length", w_len, EXP_WP);
      check(!w_bad, "R5 write pins stable with drive on and oe_n high", w_bad, 0);
    end
    rd_prev = rd_now;
    wr_prev = wr_now;
  end

  task automatic issue(input bit wr, input logic [17:0] a, input logic [7:0] d,
                       output int busy, output logic [7:0] rdat, output int rsp_seen);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    // R8: scramble the request fields once accepted
    req_valid = 1'b0; req_wr = ~wr; req_addr = ~a; req_wdata = ~d;
    busy = 0; rsp_seen = 0;
    while (!req_ready) begin
      busy++;
      if (rsp_valid) rsp_seen++;
      @(negedge clk);
    end
    if (rsp_valid) rsp_seen++;
    rdat = rsp_rdata;
    if (!wr) begin
      @(negedge clk);
      check(!rsp_valid, "R4 response pulse lasts one clock", rsp_valid, 0);
    end
  endtask

  task automatic do_write(input logic [17:0] a, input logic [7:0] d);
    int busy, seen, exp;
    logic [7:0] rd;
    exp = (last_read ? EXP_TA : 0) + EXP_WP + EXP_REC;
    issue(1'b1, a, d, busy, rd, seen);
    check(busy == exp, "R6 R7 R8 R9 write busy clocks", busy, exp);
    check(seen == 0, "R4 no response for a write", seen, 0);
    shadow[int'(a)] = d;
    last_read = 1'b0;
  endtask

  task automatic do_read(input logic [17:0] a);
    int busy, seen;
    logic [7:0] rd, exp;
    exp = shadow.exists(int'(a)) ? shadow[int'(a)] : dflt(a);
    issue(1'b0, a, 8'h00, busy, rd, seen);
    check(busy == EXP_RD, "R3 R8 R9 read busy clocks", busy, EXP_RD);
    check(seen == 1, "R4 response with ready return", seen, 1);
    check(rd == exp, "R4 R8 read data", rd, exp);
    last_read = 1'b1;
  endtask

  task automatic check_idle_pins(input string req);
    check(mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && !mem_dq_oe,
          req, {mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
    check(!rsp_valid && req_ready, req, {rsp_valid, req_ready}, 2'b01);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual 200000 clocks expected fewer");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle_pins("R1 pins in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle_pins("R1 pins after reset");

    // unwritten corners of the address space
    do_read(18'h00000);
    do_read(18'h3FFFF);

    // address bit walk
    for (int b = 0; b < 18; b++) do_write(18'(1 << b), 8'(b) ^ 8'hA5);

    // full data value sweep, each read followed directly by the next write
    for (int v = 0; v < 256; v++) begin
      do_write(18'((v * 769 + 5) & 18'h3FFFF), 8'(v));
      do_read(18'((v * 769 + 5) & 18'h3FFFF));
    end

    for (int b = 0; b < 18; b++) do_read(18'(1 << b));

    // back-to-back writes without a prior read, then read-read-write
    do_write(18'h15555, 8'h00);
    do_write(18'h2AAAA, 8'hFF);
    do_read(18'h15555);
    do_read(18'h2AAAA);
    do_write(18'h15555, 8'h81);
    do_read(18'h15555);

    repeat (2) @(negedge clk);
    check_idle_pins("R2 quiet when idle");
    check(sel_viol == 0, "R2 strobes only with both selects", sel_viol, 0);
    check(turn_events > 0, "R7 write after read exercised", turn_events, 1);
    finish_run();
  end
endmodule